// File: doc/BRIEF.md
# Bidirectional Bus Direction Steering Controller

This block steers a nine-line bidirectional path (eight data bits and one parity bit) between a single-ended side A and a differential side B. Each side's line receiver appears as one "asserted" flag per line. For every line the block produces a driver enable and a data value for each side. The parity line is routed exactly like a data line and is never checked.

Two steering modes exist. While the bus-drive input is low, each line has its own direction latch. The first side to assert a line claims it, and the latch drives the opposite side. The latch keeps that direction until both the source and the driven side read idle again. While the bus-drive input is high, a bus-wide direction select sets the direction for all nine lines. A change of the select turns the active drivers off at once. The new drivers stay off until every line on both sides reads deasserted. An active-low clear input, an active-low cable-sense input and two active-high flags (power-up hold and over-temperature) each disable all drivers and empty every latch.

Control inputs pass through two-flop synchronizers. Line flags are sampled directly. Every output is a register.

Top module: `bus_dir_steer`

## Requirements
- R1: After the synchronous reset `rst` is released and the synchronizers have settled, all of `a_oe`, `a_dout`, `b_oe` and `b_dout` read 0.
- R2: In per-line mode (`drv_bus` low), a line whose `a_rx` and `b_rx` flags are both 0 has both of its enables at 0 one clock later.
- R3: In per-line mode, an idle line whose `a_rx` asserts sets its `b_oe` bit on the next clock. An idle line whose `b_rx` asserts sets its `a_oe` bit on the next clock.
- R4: When an idle line sees `a_rx` and `b_rx` assert in the same clock, side A wins: `b_oe` is set and `a_oe` stays 0.
- R5: A claimed line keeps its direction after its source flag drops, as long as the driven side's flag is still asserted. Assertion of the driven side's flag never reverses the line. The line returns to idle only when both flags read 0.
- R6: Each of the nine lines (bit 8 is parity) steers independently, so different lines can point in opposite directions at the same time.
- R7: A rising `drv_bus` captures `dir_sel` (1 = B to A, 0 = A to B) and enables all nine drivers of the chosen side. This happens regardless of line activity, on the third clock edge after the input change (two synchronizer stages plus one output register).
- R8: When `dir_sel` changes while `drv_bus` is high, all drivers turn off. The new side is enabled only on the clock that sees all nine lines deasserted on both `a_rx` and `b_rx`.
- R9: `clr_n` low, `sense_n` low, `por_hold` high or `over_temp` high (each synchronized) disables all drivers and returns every line latch to idle.
- R10: When `drv_bus` falls, the forced drivers turn off and every line latch restarts from idle. Line activity present at that moment is claimed afresh.
- R11: For no line are `a_oe` and `b_oe` both 1 at the same time.
- R12: A data output bit is 0 unless its enable is set. When set, it equals the opposite side's flag sampled one clock earlier.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| clr_n | input | 1 | Asynchronous active-low clear request |
| sense_n | input | 1 | Asynchronous active-low cable-sense disable |
| por_hold | input | 1 | Asynchronous active-high power-up hold |
| over_temp | input | 1 | Asynchronous active-high over-temperature flag |
| drv_bus | input | 1 | Forced-direction mode select (asynchronous) |
| dir_sel | input | 1 | Forced direction: 1 = B to A, 0 = A to B (asynchronous) |
| a_rx | input | 9 | Side-A receiver asserted flags, bit 8 = parity |
| b_rx | input | 9 | Side-B receiver asserted flags, bit 8 = parity |
| a_oe | output | 9 | Side-A driver enables |
| a_dout | output | 9 | Side-A driven data |
| b_oe | output | 9 | Side-B driver enables |
| b_dout | output | 9 | Side-B driven data |

## Verification
The assertions assume that the line flags are already synchronous to `clk`. They also assume that a claimed line's flags come from a bus that settles between edges, so a one-clock data relation between source flag and driven output is meaningful. The turnaround property takes for granted that `drv_bus` and `dir_sel` reach the logic only through the synchronizers. The bench therefore changes every input on the falling clock edge. It holds control inputs steady for at least four clocks before sampling, and it keeps a line flag asserted through any window in which a release would be premature.

// File: rtl/bus_dir_steer_pkg.sv
package bus_dir_steer_pkg;
  typedef enum logic [1:0] {
    LAT_IDLE = 2'd0,
    LAT_A2B  = 2'd1,
    LAT_B2A  = 2'd2
  } lat_state_e;
endpackage

// File: rtl/bds_sync.sv
module bds_sync #(
  parameter int W      = 1,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] stg [STAGES];

  always_ff @(posedge clk) begin
    if (rst) stg[0] <= '0;
    else     stg[0] <= d;
  end

  for (genvar s = 1; s < STAGES; s++) begin : g_stage
    always_ff @(posedge clk) begin
      if (rst) stg[s] <= '0;
      else     stg[s] <= stg[s-1];
    end
  end

  assign q = stg[STAGES-1];
endmodule

// File: rtl/bds_chan_latch.sv
module bds_chan_latch
  import bus_dir_steer_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       hold_idle,
  input  logic       a_in,
  input  logic       b_in,
  output lat_state_e st_q,
  output lat_state_e st_nxt
);
  always_comb begin
    st_nxt = st_q;
    if (hold_idle) begin
      st_nxt = LAT_IDLE;
    end else begin
      unique case (st_q)
        LAT_IDLE: begin
          if (a_in)      st_nxt = LAT_A2B;
          else if (b_in) st_nxt = LAT_B2A;
        end
        LAT_A2B, LAT_B2A: begin
          if (!a_in && !b_in) st_nxt = LAT_IDLE;
        end
        default: st_nxt = LAT_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) st_q <= LAT_IDLE;
    else     st_q <= st_nxt;
  end
endmodule

// File: rtl/bds_force_ctl.sv
module bds_force_ctl (
  input  logic clk,
  input  logic rst,
  input  logic clr,
  input  logic drv_s,
  input  logic sel_s,
  input  logic quiet,
  output logic on_q,
  output logic dir_q,
  output logic prev_q,
  output logic on_nxt,
  output logic dir_nxt
);
  always_comb begin
    on_nxt  = on_q;
    dir_nxt = dir_q;
    if (clr || !drv_s) begin
      on_nxt = 1'b0;
    end else if (!prev_q) begin
      on_nxt  = 1'b1;
      dir_nxt = sel_s;
    end else if (sel_s != dir_q) begin
      on_nxt  = 1'b0;
      dir_nxt = sel_s;
    end else if (!on_q && quiet) begin
      on_nxt = 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      on_q   <= 1'b0;
      dir_q  <= 1'b0;
      prev_q <= 1'b0;
    end else begin
      on_q   <= on_nxt;
      dir_q  <= dir_nxt;
      prev_q <= clr ? 1'b0 : drv_s;
    end
  end
endmodule

// File: rtl/bus_dir_steer.sv
module bus_dir_steer
  import bus_dir_steer_pkg::*;
#(
  parameter int N_LINES     = 9,
  parameter int SYNC_STAGES = 2
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               clr_n,
  input  logic               sense_n,
  input  logic               por_hold,
  input  logic               over_temp,
  input  logic               drv_bus,
  input  logic               dir_sel,
  input  logic [N_LINES-1:0] a_rx,
  input  logic [N_LINES-1:0] b_rx,
  output logic [N_LINES-1:0] a_oe,
  output logic [N_LINES-1:0] a_dout,
  output logic [N_LINES-1:0] b_oe,
  output logic [N_LINES-1:0] b_dout
);
  localparam int N_CTRL = 6;

  logic [N_CTRL-1:0] ctrl_raw, ctrl_s;
  logic clr_n_s, sense_n_s, por_s, hot_s, drv_s, sel_s;
  logic clr_any;
  logic quiet;
  logic f_on_q, f_dir_q, f_prev_q, f_on_nxt, f_dir_nxt;
  lat_state_e st_q   [N_LINES];
  lat_state_e st_nxt [N_LINES];
  logic [N_LINES-1:0] a_en_n, b_en_n;

  assign ctrl_raw = {~clr_n, ~sense_n, por_hold, over_temp, drv_bus, dir_sel};

  bds_sync #(.W(N_CTRL), .STAGES(SYNC_STAGES)) u_sync (
    .clk (clk),
    .rst (rst),
    .d   (ctrl_raw),
    .q   (ctrl_s)
  );

  // inverted clear inputs are synchronized so reset value 0 means "not clearing"
  assign clr_n_s   = ~ctrl_s[5];
  assign sense_n_s = ~ctrl_s[4];
  assign por_s     = ctrl_s[3];
  assign hot_s     = ctrl_s[2];
  assign drv_s     = ctrl_s[1];
  assign sel_s     = ctrl_s[0];

  assign clr_any = !clr_n_s || !sense_n_s || por_s || hot_s;
  assign quiet   = (a_rx == '0) && (b_rx == '0);

  bds_force_ctl u_force (
    .clk     (clk),
    .rst     (rst),
    .clr     (clr_any),
    .drv_s   (drv_s),
    .sel_s   (sel_s),
    .quiet   (quiet),
    .on_q    (f_on_q),
    .dir_q   (f_dir_q),
    .prev_q  (f_prev_q),
    .on_nxt  (f_on_nxt),
    .dir_nxt (f_dir_nxt)
  );

  for (genvar i = 0; i < N_LINES; i++) begin : g_line
    bds_chan_latch u_lat (
      .clk       (clk),
      .rst       (rst),
      .hold_idle (clr_any || drv_s),
      .a_in      (a_rx[i]),
      .b_in      (b_rx[i]),
      .st_q      (st_q[i]),
      .st_nxt    (st_nxt[i])
    );

    always_comb begin
      if (f_on_nxt) begin
        a_en_n[i] = f_dir_nxt;
        b_en_n[i] = !f_dir_nxt;
      end else begin
        a_en_n[i] = (st_nxt[i] == LAT_B2A);
        b_en_n[i] = (st_nxt[i] == LAT_A2B);
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      a_oe   <= '0;
      b_oe   <= '0;
      a_dout <= '0;
      b_dout <= '0;
    end else begin
      a_oe   <= a_en_n;
      b_oe   <= b_en_n;
      a_dout <= a_en_n & b_rx;
      b_dout <= b_en_n & a_rx;
    end
  end
endmodule

// File: rtl/bus_dir_steer_chk.sv
module bus_dir_steer_chk #(
  parameter int N_LINES = 9
) (
  input logic               clk,
  input logic               rst,
  input logic               clr_any,
  input logic               drv_s,
  input logic               f_on_q,
  input logic               f_prev_q,
  input logic [N_LINES-1:0] a_rx,
  input logic [N_LINES-1:0] b_rx,
  input logic [N_LINES-1:0] a_oe,
  input logic [N_LINES-1:0] b_oe,
  input logic [N_LINES-1:0] a_dout,
  input logic [N_LINES-1:0] b_dout
);
  AST_NO_CONTENTION: assert property (@(posedge clk) disable iff (rst) (a_oe & b_oe) == '0); // R11
  AST_CLEAR_OFF: assert property (@(posedge clk) disable iff (rst) clr_any |=> (a_oe == '0 && b_oe == '0)); // R9
  AST_IDLE_OFF: assert property (@(posedge clk) disable iff (rst) (!drv_s && !clr_any && a_rx == '0 && b_rx == '0) |=> (a_oe == '0 && b_oe == '0)); // R2
  AST_A2B_DATA: assert property (@(posedge clk) disable iff (rst) 1'b1 |=> ((b_dout & ~b_oe) == '0 && (b_oe & (b_dout ^ $past(a_rx))) == '0)); // R12
  AST_B2A_DATA: assert property (@(posedge clk) disable iff (rst) 1'b1 |=> ((a_dout & ~a_oe) == '0 && (a_oe & (a_dout ^ $past(b_rx))) == '0)); // R12
  AST_TURN_WAIT: assert property (@(posedge clk) disable iff (rst) (drv_s && f_prev_q && !f_on_q && (a_rx | b_rx) != '0) |=> !f_on_q); // R8
endmodule

bind bus_dir_steer bus_dir_steer_chk #(.N_LINES(N_LINES)) u_chk (
  .clk      (clk),
  .rst      (rst),
  .clr_any  (clr_any),
  .drv_s    (drv_s),
  .f_on_q   (f_on_q),
  .f_prev_q (f_prev_q),
  .a_rx     (a_rx),
  .b_rx     (b_rx),
  .a_oe     (a_oe),
  .b_oe     (b_oe),
  .a_dout   (a_dout),
  .b_dout   (b_dout)
);

// File: tb/bus_dir_steer_test.sv
module bus_dir_steer_test;
  localparam int CLK_PERIOD = 10;
  localparam logic [8:0] ALL = 9'h1FF;

  logic clk = 1'b0;
  logic rst, clr_n, sense_n, por_hold, over_temp, drv_bus, dir_sel;
  logic [8:0] a_rx, b_rx, a_oe, a_dout, b_oe, b_dout;
  int checks = 0;
  int failures = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  bus_dir_steer uut (
    .clk(clk), .rst(rst), .clr_n(clr_n), .sense_n(sense_n),
    .por_hold(por_hold), .over_temp(over_temp), .drv_bus(drv_bus),
    .dir_sel(dir_sel), .a_rx(a_rx), .b_rx(b_rx),
    .a_oe(a_oe), .a_dout(a_dout), .b_oe(b_oe), .b_dout(b_dout)
  );

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input string req, input string what, input logic [8:0] act, input logic [8:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic chk_out(input string req, input logic [8:0] e_aoe, input logic [8:0] e_ad,
                         input logic [8:0] e_boe, input logic [8:0] e_bd);
    chk(req, "a_oe", a_oe, e_aoe);
    chk(req, "a_dout", a_dout, e_ad);
    chk(req, "b_oe", b_oe, e_boe);
    chk(req, "b_dout", b_dout, e_bd);
    chk("R11", "a_oe&b_oe", a_oe & b_oe, 9'h000);
  endtask

  task automatic t_reset();
    rst = 1; clr_n = 1; sense_n = 1; por_hold = 0; over_temp = 0;
    drv_bus = 0; dir_sel = 0; a_rx = '0; b_rx = '0;
    step(3);
    rst = 0;
    step(4);
    chk_out("R1", 9'h0, 9'h0, 9'h0, 9'h0);
  endtask

  task automatic t_idle();
    a_rx = '0; b_rx = '0;
    step(2);
    chk_out("R2", 9'h0, 9'h0, 9'h0, 9'h0);
  endtask

  task automatic t_capture();
    a_rx = 9'h0A5;
    step(1);
    chk_out("R3", 9'h0, 9'h0, 9'h0A5, 9'h0A5);
    a_rx = '0;
    step(1);
    chk_out("R2", 9'h0, 9'h0, 9'h0, 9'h0);
    b_rx = 9'h15A;
    step(1);
    chk_out("R3", 9'h15A, 9'h15A, 9'h0, 9'h0);
    b_rx = '0;
    step(1);
  endtask

  task automatic t_tie();
    a_rx = ALL; b_rx = ALL;
    step(1);
    chk_out("R4", 9'h0, 9'h0, ALL, ALL);
    a_rx = '0; b_rx = '0;
    step(1);
  endtask

  task automatic t_hold();
    a_rx = 9'h001;
    step(1);
    chk_out("R5", 9'h0, 9'h0, 9'h001, 9'h001);
    a_rx = '0; b_rx = 9'h001;
    step(1);
    chk_out("R5", 9'h0, 9'h0, 9'h001, 9'h000); // R12: source dropped, data follows
    step(2);
    chk_out("R5", 9'h0, 9'h0, 9'h001, 9'h000);
    b_rx = '0;
    step(1);
    chk_out("R5", 9'h0, 9'h0, 9'h0, 9'h0);
  endtask

  task automatic t_indep();
    a_rx = 9'h100; b_rx = 9'h008;
    step(1);
    chk_out("R6", 9'h008, 9'h008, 9'h100, 9'h100);
    a_rx = 9'h100; b_rx = 9'h000;
    step(1);
    chk_out("R6", 9'h0, 9'h0, 9'h100, 9'h100);
    a_rx = '0;
    step(1);
  endtask

  task automatic t_force();
    a_rx = '0; b_rx = '0;
    dir_sel = 1; drv_bus = 1;
    step(2);
    chk_out("R7", 9'h0, 9'h0, 9'h0, 9'h0);
    step(1);
    chk_out("R7", ALL, 9'h0, 9'h0, 9'h0);
    b_rx = 9'h1A5;
    step(1);
    chk_out("R12", ALL, 9'h1A5, 9'h0, 9'h0);
  endtask

  task automatic t_turn();
    b_rx = 9'h001;
    step(1);
    dir_sel = 0;
    step(4);
    chk_out("R8", 9'h0, 9'h0, 9'h0, 9'h0);
    step(3);
    chk_out("R8", 9'h0, 9'h0, 9'h0, 9'h0);
    b_rx = '0; a_rx = 9'h002;
    step(2);
    chk_out("R8", 9'h0, 9'h0, 9'h0, 9'h0);
    a_rx = '0;
    step(1);
    chk_out("R8", 9'h0, 9'h0, ALL, 9'h0);
    a_rx = 9'h0F0;
    step(1);
    chk_out("R12", 9'h0, 9'h0, ALL, 9'h0F0);
    a_rx = '0;
  endtask

  task automatic t_drvfall();
    b_rx = 9'h004;
    step(1);
    chk_out("R10", 9'h0, 9'h0, ALL, 9'h0);
    drv_bus = 0;
    step(4);
    chk_out("R10", 9'h004, 9'h004, 9'h0, 9'h0);
    dir_sel = 0; drv_bus = 1;
    step(4);
    chk_out("R7", 9'h0, 9'h0, ALL, 9'h0);
    drv_bus = 0; b_rx = '0;
    step(4);
    chk_out("R10", 9'h0, 9'h0, 9'h0, 9'h0);
  endtask

  task automatic set_src(input int which, input logic active);
    case (which)
      0: clr_n = !active;
      1: sense_n = !active;
      2: por_hold = active;
      default: over_temp = active;
    endcase
  endtask

  task automatic t_clear(input int which);
    a_rx = 9'h0FF; b_rx = '0;
    step(1);
    chk_out("R9", 9'h0, 9'h0, 9'h0FF, 9'h0FF);
    set_src(which, 1'b1);
    a_rx = '0; b_rx = 9'h0FF;
    step(4);
    chk_out("R9", 9'h0, 9'h0, 9'h0, 9'h0);
    set_src(which, 1'b0);
    step(4);
    chk_out("R9", 9'h0FF, 9'h0FF, 9'h0, 9'h0);
    b_rx = '0;
    step(1);
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    checks++;
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    t_reset();
    t_idle();
    t_capture();
    t_tie();
    t_hold();
    t_indep();
    t_force();
    t_turn();
    t_drvfall();
    for (int k = 0; k < 4; k++) t_clear(k);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule